// File: doc/BRIEF.md
# Multi-Width Integer ALU with Flags

This block is an integer arithmetic and logic unit with a registered flag set. Each operation picks its own operand width of 8, 16 or 32 bits. A caller presents a destination operand, a source operand (or a sign-extended 8-bit immediate in its place), an operation code and a size code, and strobes `op_valid`. One clock later the block shows the merged result, a write-enable telling the caller whether to store it, and the updated carry, zero, sign, overflow, parity and auxiliary flags. The flags stay as they are until the next operation changes them.

The carry used by add-with-carry and subtract-with-borrow is the block's own registered carry flag, so a multi-word add or subtract can be chained with back-to-back operations. Each operation has its own flag-update rule. Increment and decrement keep the carry. Compare and test change the flags but produce no write. Test and the bitwise operations clear carry and overflow. Negation takes its carry from a nonzero check. Complement touches no flag.

A two-state machine tracks result presentation. State `ST_IDLE` presents no result. State `ST_HOLD` presents the result of the operation accepted on the previous edge. The transitions are: IDLE to HOLD on accept, HOLD to HOLD on a back-to-back accept, HOLD to IDLE when no operation arrives, and IDLE to IDLE when idle.

Top module: `alu_flag_unit`

## Requirements
- R1: While reset is held and after it is released, with no operation accepted, `res_valid`, `res_we`, `res_data` and all six flags read 0.
- R2: An operation sampled with `op_valid` high at a rising edge raises `res_valid` for the cycle after that edge only. With `op_valid` low, `res_valid` and `res_we` read 0 one cycle later and the flags keep their values.
- R3: Add (code 0) gives dst + src, and add-with-carry (code 1) gives dst + src + C, where C is the registered carry flag. Carry is the carry out of the top bit at the active width, and `res_we` is 1.
- R4: Subtract (code 2) gives dst − src, and subtract-with-borrow (code 3) gives dst − (src + C). Carry is the borrow out of the top bit at the active width. Compare (code 4) computes dst − src into `res_data` and sets the flags as subtract does, with `res_we` = 0.
- R5: When `imm_sel` is 1, the source is `imm_val` sign-extended to the active width, and `src_b` is ignored.
- R6: Increment (code 5) adds 1 and decrement (code 6) subtracts 1. Both set Z, S, O, P and A as add or subtract does, and leave C at its previous value.
- R7: Test (code 7) forms dst AND src and sets Z, S and P from it, clears C, O and A, and gives `res_we` = 0.
- R8: AND (code 8), OR (code 9) and XOR (code 10) write the bitwise result with `res_we` = 1. They clear C, O and A, and set Z, S and P from the result.
- R9: Complement (code 11) writes every destination bit inverted at the active width, with `res_we` = 1. All six flags are unchanged.
- R10: Negate (code 12) writes 0 − dst. C is 0 when dst is zero at the active width and 1 otherwise. The other flags are set as subtract sets them.
- R11: Size code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Bits of `res_data` above the active width equal the same bits of `dst_a`.
- R12: P is 1 when the low 8 result bits hold an even number of ones. Z is 1 when every result bit at the active width is 0. S is the top result bit at the active width. O is signed overflow at the active width. A is the carry (for add) or borrow (for subtract) out of bit 3.
- R13: Codes 13 to 15 are reserved. They give `res_we` = 0, leave all flags unchanged, and return `dst_a` in `res_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| op_size | input | 2 | Operand width code |
| imm_sel | input | 1 | Use the immediate as the source |
| imm_val | input | 8 | Immediate value, sign-extended when used |
| dst_a | input | 32 | Destination operand (first operand) |
| src_b | input | 32 | Source operand (second operand) |
| res_valid | output | 1 | Result of the previous accepted operation is shown |
| res_we | output | 1 | Result should be written back |
| res_data | output | 32 | Merged result |
| flag_c | output | 1 | Carry / borrow flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_o | output | 1 | Overflow flag |
| flag_p | output | 1 | Parity flag |
| flag_a | output | 1 | Auxiliary (bit 3) carry flag |

## Verification
The properties assume that `op_valid`, `op_code` and `op_size` are never unknown once reset is released, and that `dst_a` is known whenever an operation is accepted. Without this, the checks of the carry after negate and of the upper bits after a byte operation could not be decided. The stimulus drives every input to a defined value at time zero and changes inputs only on the falling clock edge. It holds reset over several edges before the first operation. Its randomized phase draws every code from 0 to 15 and every size code from 0 to 3, so the reserved opcodes and the size code that aliases 32 bits are both covered.

// File: rtl/alu_pkg.sv
package alu_pkg;

    parameter int ALU_BYTE_W    = 8;
    parameter int ALU_NUM_SIZES = 3;
    localparam int OP_W         = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_CMP  = 4'd4,
        OP_INC  = 4'd5,
        OP_DEC  = 4'd6,
        OP_TEST = 4'd7,
        OP_AND  = 4'd8,
        OP_OR   = 4'd9,
        OP_XOR  = 4'd10,
        OP_NOT  = 4'd11,
        OP_NEG  = 4'd12
    } alu_op_e;

    // How the flag register is updated for an operation
    typedef enum logic [1:0] {
        FCLS_ARITH = 2'd0,   // every flag from the adder
        FCLS_KEEPC = 2'd1,   // adder flags, carry preserved
        FCLS_LOGIC = 2'd2,   // C/O/A cleared, Z/S/P from result
        FCLS_NONE  = 2'd3    // all flags preserved
    } flag_cls_e;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic o;
        logic p;
        logic a;
    } alu_flags_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } pres_state_e;

endpackage

// File: rtl/alu_width_ctl.sv
module alu_width_ctl #(
    parameter int BYTE_W    = 8,
    parameter int NUM_SIZES = 3,
    localparam int DATA_W   = BYTE_W << (NUM_SIZES - 1),
    localparam int SZ_W     = (NUM_SIZES > 1) ? $clog2(NUM_SIZES) : 1
) (
    input  logic [SZ_W-1:0]   size_sel,
    output logic [DATA_W-1:0] lane_mask,
    output logic [DATA_W-1:0] msb_bit
);

    logic [DATA_W-1:0] mask_tbl [NUM_SIZES];

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_lane
        localparam int LW = BYTE_W << k;
        assign mask_tbl[k] = DATA_W'({LW{1'b1}});
    end

    always_comb begin
        // Codes past the last size alias the widest lane
        if (int'(size_sel) >= NUM_SIZES) begin
            lane_mask = mask_tbl[NUM_SIZES-1];
        end else begin
            lane_mask = mask_tbl[size_sel];
        end
        msb_bit = lane_mask ^ (lane_mask >> 1);
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              cin,
    input  logic              subtract,
    input  logic [DATA_W-1:0] msb_bit,
    output logic [DATA_W-1:0] sum,
    output logic              carry_flag,
    output logic              ovf_flag,
    output logic              aux_flag
);

    localparam int NIBBLE = 4;

    logic [DATA_W-1:0] b_x;
    logic              c0;
    logic [DATA_W:0]   sum_x;
    logic [DATA_W:0]   cv;
    logic              c_out;
    logic              c_msb;

    always_comb begin
        // Subtraction as a + ~b + ~borrow_in
        b_x   = subtract ? ~opb : opb;
        c0    = subtract ? ~cin : cin;
        sum_x = {1'b0, opa} + {1'b0, b_x} + {{DATA_W{1'b0}}, c0};
        // cv[i] is the carry into bit i
        cv    = sum_x ^ {1'b0, opa} ^ {1'b0, b_x};
        c_out = |(cv[DATA_W:1] & msb_bit);
        c_msb = |(cv[DATA_W-1:0] & msb_bit);
        sum        = sum_x[DATA_W-1:0];
        carry_flag = c_out ^ subtract;
        ovf_flag   = c_out ^ c_msb;
        aux_flag   = cv[NIBBLE] ^ subtract;
    end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  flag_cls_e         cls,
    input  logic              neg_op,
    input  logic              operand_nz,
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] msb_bit,
    input  logic              ar_c,
    input  logic              ar_o,
    input  logic              ar_a,
    input  alu_flags_t        flags_cur,
    output alu_flags_t        flags_nxt
);

    localparam int PAR_W = 8;

    logic zf;
    logic sf;
    logic pf;

    always_comb begin
        zf = (value == '0);
        sf = |(value & msb_bit);
        pf = ~^value[PAR_W-1:0];

        flags_nxt = flags_cur;
        unique case (cls)
            FCLS_ARITH: begin
                flags_nxt.c = neg_op ? operand_nz : ar_c;
                flags_nxt.o = ar_o;
                flags_nxt.a = ar_a;
                flags_nxt.z = zf;
                flags_nxt.s = sf;
                flags_nxt.p = pf;
            end
            FCLS_KEEPC: begin
                flags_nxt.o = ar_o;
                flags_nxt.a = ar_a;
                flags_nxt.z = zf;
                flags_nxt.s = sf;
                flags_nxt.p = pf;
            end
            FCLS_LOGIC: begin
                flags_nxt.c = 1'b0;
                flags_nxt.o = 1'b0;
                flags_nxt.a = 1'b0;
                flags_nxt.z = zf;
                flags_nxt.s = sf;
                flags_nxt.p = pf;
            end
            FCLS_NONE: begin
                flags_nxt = flags_cur;
            end
            default: begin
                flags_nxt = flags_cur;
            end
        endcase
    end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_pkg::*;
#(
    parameter int BYTE_W    = ALU_BYTE_W,
    parameter int NUM_SIZES = ALU_NUM_SIZES,
    localparam int DATA_W   = BYTE_W << (NUM_SIZES - 1),
    localparam int SZ_W     = (NUM_SIZES > 1) ? $clog2(NUM_SIZES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [SZ_W-1:0]   op_size,
    input  logic              imm_sel,
    input  logic [BYTE_W-1:0] imm_val,
    input  logic [DATA_W-1:0] dst_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              res_valid,
    output logic              res_we,
    output logic [DATA_W-1:0] res_data,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_s,
    output logic              flag_o,
    output logic              flag_p,
    output logic              flag_a
);

    pres_state_e       state_q, state_d;
    alu_flags_t        flags_q, flags_d;
    logic [DATA_W-1:0] data_q;
    logic              we_q;

    logic [DATA_W-1:0] lane_mask, msb_bit;
    logic [DATA_W-1:0] src_eff;
    alu_op_e           op_e;

    logic [DATA_W-1:0] as_a, as_b, as_sum;
    logic              as_cin, as_sub;
    logic              as_c, as_o, as_a_flag;

    logic [DATA_W-1:0] pick;
    logic [DATA_W-1:0] merged;
    logic              we_d;
    logic              neg_op;
    flag_cls_e         cls;

    assign op_e    = alu_op_e'(op_code);
    assign src_eff = imm_sel ? {{(DATA_W-BYTE_W){imm_val[BYTE_W-1]}}, imm_val} : src_b;

    alu_width_ctl #(
        .BYTE_W    (BYTE_W),
        .NUM_SIZES (NUM_SIZES)
    ) u_width (
        .size_sel  (op_size),
        .lane_mask (lane_mask),
        .msb_bit   (msb_bit)
    );

    // Operation decode: adder operands, result source, flag class
    always_comb begin
        as_a   = dst_a;
        as_b   = src_eff;
        as_cin = 1'b0;
        as_sub = 1'b0;
        pick   = dst_a;
        we_d   = 1'b0;
        neg_op = 1'b0;
        cls    = FCLS_NONE;
        case (op_e)
            OP_ADD: begin
                pick = as_sum; we_d = 1'b1; cls = FCLS_ARITH;
            end
            OP_ADC: begin
                as_cin = flags_q.c;
                pick = as_sum; we_d = 1'b1; cls = FCLS_ARITH;
            end
            OP_SUB: begin
                as_sub = 1'b1;
                pick = as_sum; we_d = 1'b1; cls = FCLS_ARITH;
            end
            OP_SBB: begin
                as_sub = 1'b1; as_cin = flags_q.c;
                pick = as_sum; we_d = 1'b1; cls = FCLS_ARITH;
            end
            OP_CMP: begin
                as_sub = 1'b1;
                pick = as_sum; cls = FCLS_ARITH;
            end
            OP_INC: begin
                as_b = DATA_W'(1);
                pick = as_sum; we_d = 1'b1; cls = FCLS_KEEPC;
            end
            OP_DEC: begin
                as_b = DATA_W'(1); as_sub = 1'b1;
                pick = as_sum; we_d = 1'b1; cls = FCLS_KEEPC;
            end
            OP_TEST: begin
                pick = dst_a & src_eff; cls = FCLS_LOGIC;
            end
            OP_AND: begin
                pick = dst_a & src_eff; we_d = 1'b1; cls = FCLS_LOGIC;
            end
            OP_OR: begin
                pick = dst_a | src_eff; we_d = 1'b1; cls = FCLS_LOGIC;
            end
            OP_XOR: begin
                pick = dst_a ^ src_eff; we_d = 1'b1; cls = FCLS_LOGIC;
            end
            OP_NOT: begin
                pick = ~dst_a; we_d = 1'b1; cls = FCLS_NONE;
            end
            OP_NEG: begin
                as_a = '0; as_b = dst_a; as_sub = 1'b1; neg_op = 1'b1;
                pick = as_sum; we_d = 1'b1; cls = FCLS_ARITH;
            end
            default: begin
                pick = dst_a; we_d = 1'b0; cls = FCLS_NONE;
            end
        endcase
        merged = (dst_a & ~lane_mask) | (pick & lane_mask);
    end

    alu_addsub #(
        .DATA_W (DATA_W)
    ) u_addsub (
        .opa        (as_a),
        .opb        (as_b),
        .cin        (as_cin),
        .subtract   (as_sub),
        .msb_bit    (msb_bit),
        .sum        (as_sum),
        .carry_flag (as_c),
        .ovf_flag   (as_o),
        .aux_flag   (as_a_flag)
    );

    alu_flag_gen #(
        .DATA_W (DATA_W)
    ) u_flags (
        .cls        (cls),
        .neg_op     (neg_op),
        .operand_nz (|(dst_a & lane_mask)),
        .value      (pick & lane_mask),
        .msb_bit    (msb_bit),
        .ar_c       (as_c),
        .ar_o       (as_o),
        .ar_a       (as_a_flag),
        .flags_cur  (flags_q),
        .flags_nxt  (flags_d)
    );

    // Presentation state machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = op_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = op_valid ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            we_q    <= 1'b0;
            flags_q <= '0;
        end else if (op_valid) begin
            data_q  <= merged;
            we_q    <= we_d;
            flags_q <= flags_d;
        end else begin
            we_q    <= 1'b0;
        end
    end

    assign res_valid = (state_q == ST_HOLD);
    assign res_we    = we_q;
    assign res_data  = data_q;
    assign flag_c    = flags_q.c;
    assign flag_z    = flags_q.z;
    assign flag_s    = flags_q.s;
    assign flag_o    = flags_q.o;
    assign flag_p    = flags_q.p;
    assign flag_a    = flags_q.a;

endmodule

module alu_flag_unit_chk
    import alu_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DATA_W = 32,
    parameter int SZ_W   = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     op_valid,
    input logic [OP_W-1:0]          op_code,
    input logic [SZ_W-1:0]          op_size,
    input logic [DATA_W-1:0]        dst_a,
    input logic                     res_valid,
    input logic                     res_we,
    input logic [DATA_W-1:BYTE_W]   res_hi,
    input logic                     flag_c,
    input logic                     flag_z,
    input logic                     flag_s,
    input logic                     flag_o,
    input logic                     flag_p,
    input logic                     flag_a
);

    logic [5:0] fl_vec;
    assign fl_vec = {flag_c, flag_z, flag_s, flag_o, flag_p, flag_a};

    a_r2_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !res_we));

    a_r2_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(fl_vec));

    a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CMP) |=> !res_we);

    a_r6_incdec_keep_c: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_INC || op_code == OP_DEC)) |=> (flag_c == $past(flag_c)));

    a_r7_test_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_TEST) |=> (!flag_c && !flag_o && !res_we));

    a_r9_not_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_NOT) |=> $stable(fl_vec));

    a_r10_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_NEG && dst_a == '0) |=> (!flag_c && flag_z));

    a_r11_byte_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_size == '0) |=> (res_hi == $past(dst_a[DATA_W-1:BYTE_W])));

    a_r13_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code > OP_NEG) |=> (!res_we && $stable(fl_vec)));

endmodule

bind alu_flag_unit alu_flag_unit_chk #(
    .BYTE_W (BYTE_W),
    .DATA_W (DATA_W),
    .SZ_W   (SZ_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_size   (op_size),
    .dst_a     (dst_a),
    .res_valid (res_valid),
    .res_we    (res_we),
    .res_hi    (res_data[DATA_W-1:BYTE_W]),
    .flag_c    (flag_c),
    .flag_z    (flag_z),
    .flag_s    (flag_s),
    .flag_o    (flag_o),
    .flag_p    (flag_p),
    .flag_a    (flag_a)
);

// File: tb/alu_flag_unit_tb_top.sv
`timescale 1ns/1ps
module alu_flag_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [1:0]  op_size = '0;
    logic        imm_sel = 1'b0;
    logic [7:0]  imm_val = '0;
    logic [31:0] dst_a = '0;
    logic [31:0] src_b = '0;
    logic        res_valid, res_we;
    logic [31:0] res_data;
    logic        flag_c, flag_z, flag_s, flag_o, flag_p, flag_a;

    always #2 clk = ~clk;

    alu_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_size(op_size), .imm_sel(imm_sel), .imm_val(imm_val),
        .dst_a(dst_a), .src_b(src_b), .res_valid(res_valid), .res_we(res_we),
        .res_data(res_data), .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s),
        .flag_o(flag_o), .flag_p(flag_p), .flag_a(flag_a)
    );

    typedef struct {
        logic [31:0] data;
        logic        we;
        logic [5:0]  fl;   // {c,z,s,o,p,a}
        string       tag;
    } exp_t;

    exp_t       sb_q[$];
    exp_t       mon_e;
    int         n_run = 0;
    int         n_fail = 0;
    logic [5:0] mdl_fl = '0;
    bit         done = 1'b0;
    wire  [5:0] dut_fl = {flag_c, flag_z, flag_s, flag_o, flag_p, flag_a};

    function automatic longint sx(input longint unsigned v, input int w);
        if (((v >> (w - 1)) & 64'd1) != 0) return longint'(v) - (longint'(1) << w);
        return longint'(v);
    endfunction

    function automatic bit ovf(input longint r, input int w);
        return (r > ((longint'(1) << (w - 1)) - 1)) || (r < -(longint'(1) << (w - 1)));
    endfunction

    function automatic void m_add(input longint unsigned a, input longint unsigned b,
                                  input bit ci, input int w, output longint unsigned r,
                                  output bit c, output bit o, output bit ax);
        longint unsigned t;
        t  = a + b + 64'(ci);
        r  = t & ((64'd1 << w) - 1);
        c  = ((t >> w) & 64'd1) != 0;
        ax = ((a & 15) + (b & 15) + 64'(ci)) > 15;
        o  = ovf(sx(a, w) + sx(b, w) + longint'(ci), w);
    endfunction

    function automatic void m_sub(input longint unsigned a, input longint unsigned b,
                                  input bit ci, input int w, output longint unsigned r,
                                  output bit c, output bit o, output bit ax);
        longint unsigned t;
        t  = a - b - 64'(ci);
        r  = t & ((64'd1 << w) - 1);
        c  = a < (b + 64'(ci));
        ax = (a & 15) < ((b & 15) + 64'(ci));
        o  = ovf(sx(a, w) - sx(b, w) - longint'(ci), w);
    endfunction

    function automatic exp_t model(input int op, input int sz, input bit isel,
                                   input logic [7:0] imm, input logic [31:0] dst,
                                   input logic [31:0] src, input logic [5:0] fin);
        exp_t e;
        int w;
        longint unsigned mask, a, b, r;
        bit c, z, s, o, p, ax, newc, upd;
        logic [31:0] bs;
        w    = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        mask = (64'd1 << w) - 1;
        bs   = isel ? {{24{imm[7]}}, imm} : src;
        a    = 64'(dst) & mask;
        b    = 64'(bs) & mask;
        {c, z, s, o, p, ax} = fin;
        newc = c;
        r    = a;
        e.we = 1'b0;
        upd  = 1'b1;
        case (op)
            0:  begin m_add(a, b, 1'b0, w, r, newc, o, ax); e.we = 1'b1; end
            1:  begin m_add(a, b, fin[5], w, r, newc, o, ax); e.we = 1'b1; end
            2:  begin m_sub(a, b, 1'b0, w, r, newc, o, ax); e.we = 1'b1; end
            3:  begin m_sub(a, b, fin[5], w, r, newc, o, ax); e.we = 1'b1; end
            4:  begin m_sub(a, b, 1'b0, w, r, newc, o, ax); end
            5:  begin m_add(a, 64'd1, 1'b0, w, r, c, o, ax); newc = fin[5]; e.we = 1'b1; end
            6:  begin m_sub(a, 64'd1, 1'b0, w, r, c, o, ax); newc = fin[5]; e.we = 1'b1; end
            7:  begin r = a & b; newc = 0; o = 0; ax = 0; end
            8:  begin r = a & b; newc = 0; o = 0; ax = 0; e.we = 1'b1; end
            9:  begin r = a | b; newc = 0; o = 0; ax = 0; e.we = 1'b1; end
            10: begin r = a ^ b; newc = 0; o = 0; ax = 0; e.we = 1'b1; end
            11: begin r = ~a & mask; upd = 1'b0; e.we = 1'b1; end
            12: begin m_sub(64'd0, a, 1'b0, w, r, c, o, ax); newc = (a != 0); e.we = 1'b1; end
            default: begin r = a; upd = 1'b0; end
        endcase
        if (upd) begin
            z = (r == 0);
            s = ((r >> (w - 1)) & 64'd1) != 0;
            p = ~^r[7:0];
            e.fl = {newc, z, s, o, p, ax};
        end else begin
            e.fl = fin;
        end
        e.data = (dst & ~mask[31:0]) | r[31:0];
        return e;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && !done && res_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R2", "result without accepted op", 64'(res_valid), 64'd0);
            end else begin
                mon_e = sb_q.pop_front();
                n_run++;
                if (res_data !== mon_e.data || res_we !== mon_e.we || dut_fl !== mon_e.fl) begin
                    n_fail++;
                    $display("FAIL %s: actual data=%h we=%b fl=%b expected data=%h we=%b fl=%b",
                             mon_e.tag, res_data, res_we, dut_fl, mon_e.data, mon_e.we, mon_e.fl);
                end
            end
        end
    end

    // Driver: caller is at a falling edge
    task automatic do_op(input int op, input int sz, input bit isel, input logic [7:0] imm,
                         input logic [31:0] dst, input logic [31:0] src, input string tag);
        exp_t e;
        e = model(op, sz, isel, imm, dst, src, mdl_fl);
        mdl_fl = e.fl;
        e.tag = tag;
        sb_q.push_back(e);
        op_code  = op[3:0];
        op_size  = sz[1:0];
        imm_sel  = isel;
        imm_val  = imm;
        dst_a    = dst;
        src_b    = src;
        op_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic hold_check();
        op_valid = 1'b0;
        src_b    = 32'h5A5A_5A5A;
        @(negedge clk);
        @(negedge clk);
        chk(res_valid == 1'b0, "R2", "res_valid after idle", 64'(res_valid), 64'd0);
        chk(res_we == 1'b0, "R2", "res_we after idle", 64'(res_we), 64'd0);
        chk(dut_fl == mdl_fl, "R2", "flags held while idle", 64'(dut_fl), 64'(mdl_fl));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while in reset
        chk(res_valid == 1'b0 && res_we == 1'b0, "R1", "valid/we in reset",
            64'({res_valid, res_we}), 64'd0);
        chk(res_data == 32'd0, "R1", "data in reset", 64'(res_data), 64'd0);
        chk(dut_fl == 6'd0, "R1", "flags in reset", 64'(dut_fl), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid == 1'b0 && dut_fl == 6'd0, "R1", "idle after reset",
            64'({res_valid, dut_fl}), 64'd0);

        // R3/R12: byte add with signed overflow, upper bits kept (R11)
        do_op(0, 0, 0, 8'h00, 32'hAABBCC7F, 32'h00000001, "R3");
        // R3/R12: byte add wrapping to zero with carry
        do_op(0, 0, 0, 8'h00, 32'h000000FF, 32'h00000001, "R12");
        // R3: 16-bit carry chained into add-with-carry
        do_op(0, 1, 0, 8'h00, 32'h0000FFFF, 32'h00000001, "R3");
        do_op(1, 1, 0, 8'h00, 32'h00000001, 32'h00000000, "R3");
        hold_check();
        // R4: borrow, subtract-with-borrow, compare
        do_op(2, 2, 0, 8'h00, 32'h00000000, 32'h00000001, "R4");
        do_op(3, 2, 0, 8'h00, 32'h00000005, 32'h00000002, "R4");
        do_op(4, 2, 0, 8'h00, 32'h00000003, 32'h00000005, "R4");
        // R5: sign-extended immediate (-126, -1), src_b ignored
        do_op(0, 1, 1, 8'h82, 32'h12341000, 32'hFFFFFFFF, "R5");
        do_op(2, 2, 1, 8'hFF, 32'h00000000, 32'h00000000, "R5");
        // R6: increment/decrement keep carry (C is 1 here)
        do_op(5, 0, 0, 8'h00, 32'h000000FF, 32'h0, "R6");
        do_op(6, 1, 0, 8'h00, 32'h00010000, 32'h0, "R6");
        do_op(0, 0, 0, 8'h00, 32'h1, 32'h1, "R6");
        do_op(5, 2, 0, 8'h00, 32'h7FFFFFFF, 32'h0, "R6");
        // R7: test, R8: bitwise ops
        do_op(7, 2, 0, 8'h00, 32'hF0F0F0F0, 32'h80000000, "R7");
        do_op(8, 1, 0, 8'h00, 32'hABCD1234, 32'h0000FF00, "R8");
        do_op(9, 0, 0, 8'h00, 32'h11111100, 32'h00000000, "R8");
        do_op(10, 2, 0, 8'h00, 32'hFFFF0000, 32'hFFFF0001, "R8");
        // R9: complement with flags untouched
        do_op(2, 0, 0, 8'h00, 32'h0, 32'h1, "R9");
        do_op(11, 0, 0, 8'h00, 32'h123456A5, 32'h0, "R9");
        do_op(11, 1, 0, 8'h00, 32'h0000FFFF, 32'h0, "R9");
        // R10: negate zero and the most negative byte
        do_op(12, 0, 0, 8'h00, 32'hFFFFFF00, 32'h0, "R10");
        do_op(12, 0, 0, 8'h00, 32'h00000080, 32'h0, "R10");
        do_op(12, 2, 0, 8'h00, 32'h00000001, 32'h0, "R10");
        // R11: size code 3 acts as 32 bits
        do_op(0, 3, 0, 8'h00, 32'hFFFFFFFF, 32'h00000001, "R11");
        // R13: reserved codes
        do_op(13, 2, 0, 8'h00, 32'hCAFEF00D, 32'h12345678, "R13");
        do_op(14, 0, 0, 8'h00, 32'h00000000, 32'hFFFFFFFF, "R13");
        do_op(15, 1, 1, 8'h80, 32'h0000ABCD, 32'h0, "R13");
        hold_check();

        // R12: mixed codes, sizes and operand patterns
        for (int i = 0; i < 300; i++) begin
            do_op(int'($urandom_range(0, 15)), int'($urandom_range(0, 3)),
                  bit'($urandom_range(0, 1)), 8'($urandom), $urandom, $urandom, "R12");
            if ((i % 37) == 0) hold_check();
        end
        hold_check();
        chk(sb_q.size() == 0, "R2", "pending results at end", 64'(sb_q.size()), 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL R2 watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule